// File: doc/BRIEF.md
# Machine-Mode Privilege and Trap Status Unit

This unit keeps the hart's current privilege level, Machine or User, together with the machine status fields that trap entry and trap return change. The fields are the global interrupt enable, its saved copy, the saved previous privilege and the modify-privilege flag for data accesses. It also holds the exception PC, the trap cause and the trap vector base. The pipeline raises `trap_req` with a cause and the PC of the faulting instruction, or pulses `mret_req` to return. Software reaches the four registers through CSR write, set and clear operations.

The unit reports the current privilege and the privilege that loads and stores must be checked against. When a trap or a return is accepted, it also reports the PC to fetch next. A return always leaves the saved-privilege field at User. It clears the modify-privilege flag only when the return lands in User mode. Every state change takes effect at the next clock edge, so the first load or store after a return already sees the new data-access privilege.

Top module: `mach_priv_ctrl`

## Requirements
- R1: After reset, `priv_cur` is Machine (2'b11), and mstatus, mepc and mcause all read as zero.
- R2: The mstatus CSR (address 0x300) holds MIE at bit 3, MPIE at bit 7, MPP at bits 12:11 and MPRV at bit 17, and every other bit reads as zero. `csr_op` encodings are 0 for no write, 1 for write, 2 for set bits and 3 for clear bits.
- R3: An MPP value of 2'b01 or 2'b10, whether written or produced by set or clear, is stored as User (2'b00). Only 2'b11 (Machine) and 2'b00 (User) are ever held.
- R4: An accepted trap stores `trap_pc` (bit 0 forced to zero) in mepc and `trap_cause` in mcause. It copies MIE into MPIE, clears MIE, records the prior privilege in MPP and enters Machine mode. MPRV is left unchanged.
- R5: While `trap_req` is high, `redirect_valid` is 1 and `redirect_pc` equals mtvec, whose bits 1:0 always read as zero.
- R6: An accepted MRET sets the privilege to the old MPP, copies MPIE into MIE, sets MPIE to 1 and sets MPP to User.
- R7: An MRET whose old MPP is User clears MPRV. An MRET whose old MPP is Machine leaves MPRV unchanged.
- R8: While an MRET is accepted, `redirect_valid` is 1 and `redirect_pc` equals mepc.
- R9: `priv_ls` equals MPP when MPRV is 1 and the privilege is Machine, and equals `priv_cur` otherwise. A change made by an MRET is visible in the cycle right after it.
- R10: A trap wins over an MRET requested in the same cycle. A CSR write, set or clear issued in a cycle with a trap or an MRET is dropped.
- R11: mtvec sits at 0x305, mepc at 0x341 (bit 0 reads zero) and mcause at 0x342 (low 4 bits kept). Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_cause | input | 4 | Cause code recorded on a trap |
| trap_pc | input | 32 | PC of the faulting instruction |
| mret_req | input | 1 | Return from machine trap this cycle |
| csr_op | input | 2 | 0 none, 1 write, 2 set, 3 clear |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 32 | CSR write operand |
| priv_cur | output | 2 | Current privilege (11 Machine, 00 User) |
| priv_ls | output | 2 | Effective privilege for loads and stores |
| redirect_valid | output | 1 | A trap or MRET redirects fetch this cycle |
| redirect_pc | output | 32 | Next fetch PC when redirecting |
| csr_rdata | output | 32 | Read data for `csr_addr` (value before this cycle's update) |

## Verification
A wrong MPP or MPRV after a return shows up on `priv_ls` in the very next cycle, before any CSR read. It also shows in the mstatus value read back at the following read. A lost MIE/MPIE swap stays hidden on the privilege outputs and appears only in the mstatus read, so each trap and return step in the bench reads mstatus back. Redirect targets are combinational and are checked within the request cycle. A wrong mepc or mcause is seen on the next read of those addresses.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int XLEN   = 32;
  localparam int CSR_AW = 12;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef enum logic [1:0] {
    CSR_NONE  = 2'd0,
    CSR_WRITE = 2'd1,
    CSR_SET   = 2'd2,
    CSR_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [CSR_AW-1:0] ADDR_STATUS = 12'h300;
  localparam logic [CSR_AW-1:0] ADDR_TVEC   = 12'h305;
  localparam logic [CSR_AW-1:0] ADDR_EPC    = 12'h341;
  localparam logic [CSR_AW-1:0] ADDR_CAUSE  = 12'h342;

  localparam int IE_BIT   = 3;
  localparam int PIE_BIT  = 7;
  localparam int PP_LO    = 11;
  localparam int MPRV_BIT = 17;

  // Only Machine and User are legal saved privileges.
  function automatic logic [1:0] legal_mpp(input logic [1:0] v);
    return (v == PRIV_M) ? PRIV_M : PRIV_U;
  endfunction

  function automatic logic [XLEN-1:0] pack_status(input logic ie, input logic pie,
                                                  input logic [1:0] pp, input logic prv);
    logic [XLEN-1:0] r;
    r = '0;
    r[IE_BIT]          = ie;
    r[PIE_BIT]         = pie;
    r[PP_LO+1:PP_LO]   = pp;
    r[MPRV_BIT]        = prv;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] csr_merge(input csr_op_e op, input logic [XLEN-1:0] old,
                                                input logic [XLEN-1:0] wd);
    case (op)
      CSR_WRITE: return wd;
      CSR_SET:   return old | wd;
      CSR_CLEAR: return old & ~wd;
      default:   return old;
    endcase
  endfunction

  function automatic logic [1:0] ls_priv_of(input logic [1:0] cur, input logic [1:0] pp,
                                            input logic prv);
    return (prv && cur == PRIV_M) ? pp : cur;
  endfunction
endpackage

// File: rtl/mpc_status.sv
module mpc_status
  import mpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_trap,
  input  logic            take_mret,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_val,
  output logic [1:0]      priv,
  output logic            ie,
  output logic            pie,
  output logic [1:0]      pp,
  output logic            prv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv <= PRIV_M;
      ie   <= 1'b0;
      pie  <= 1'b0;
      pp   <= PRIV_U;
      prv  <= 1'b0;
    end else if (take_trap) begin
      pie  <= ie;
      ie   <= 1'b0;
      pp   <= priv;
      priv <= PRIV_M;
    end else if (take_mret) begin
      priv <= pp;
      ie   <= pie;
      pie  <= 1'b1;
      pp   <= PRIV_U;
      if (pp != PRIV_M) prv <= 1'b0;
    end else if (wr_en) begin
      ie   <= wr_val[IE_BIT];
      pie  <= wr_val[PIE_BIT];
      pp   <= legal_mpp(wr_val[PP_LO+1:PP_LO]);
      prv  <= wr_val[MPRV_BIT];
    end
  end
endmodule

// File: rtl/mpc_trapregs.sv
module mpc_trapregs
  import mpc_pkg::*;
#(
  parameter int              CAUSE_W   = 4,
  parameter logic [XLEN-1:0] TVEC_RST  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_trap,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               epc_we,
  input  logic               cause_we,
  input  logic               tvec_we,
  input  logic [XLEN-1:0]    wdata,
  output logic [XLEN-1:0]    epc,
  output logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    tvec
);
  localparam logic [XLEN-1:0] EPC_MASK  = ~XLEN'(1);
  localparam logic [XLEN-1:0] TVEC_MASK = ~XLEN'(3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
      tvec  <= TVEC_RST & TVEC_MASK;
    end else begin
      if (take_trap) begin
        epc   <= trap_pc & EPC_MASK;
        cause <= trap_cause;
      end else begin
        if (epc_we)   epc   <= wdata & EPC_MASK;
        if (cause_we) cause <= wdata[CAUSE_W-1:0];
      end
      if (tvec_we) tvec <= wdata & TVEC_MASK;
    end
  end
endmodule

// File: rtl/mpc_csr_mux.sv
module mpc_csr_mux
  import mpc_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic [CSR_AW-1:0]  addr,
  input  logic [XLEN-1:0]    status_v,
  input  logic [XLEN-1:0]    tvec,
  input  logic [XLEN-1:0]    epc,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    rdata
);
  localparam int PAD_W = XLEN - CAUSE_W;

  always_comb begin
    case (addr)
      ADDR_STATUS: rdata = status_v;
      ADDR_TVEC:   rdata = tvec;
      ADDR_EPC:    rdata = epc;
      ADDR_CAUSE:  rdata = {{PAD_W{1'b0}}, cause};
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/mach_priv_ctrl.sv
module mach_priv_ctrl
  import mpc_pkg::*;
#(
  parameter int              CAUSE_W  = 4,
  parameter logic [XLEN-1:0] TVEC_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic               mret_req,
  input  logic [1:0]         csr_op,
  input  logic [CSR_AW-1:0]  csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [1:0]         priv_cur,
  output logic [1:0]         priv_ls,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic [XLEN-1:0]    csr_rdata
);
  // Named events, visible to the bound checker.
  logic take_trap, take_mret, csr_wr_ok;
  logic [XLEN-1:0] csr_new;

  logic            st_ie, st_pie, st_mprv;
  logic [1:0]      st_mpp;
  logic [XLEN-1:0] st_mepc, st_mtvec, st_status;
  logic [CAUSE_W-1:0] st_cause;

  assign take_trap = trap_req;
  assign take_mret = mret_req & ~trap_req;
  assign csr_wr_ok = (csr_op != CSR_NONE) & ~trap_req & ~mret_req;
  assign csr_new   = csr_merge(csr_op_e'(csr_op), csr_rdata, csr_wdata);

  mpc_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_trap (take_trap),
    .take_mret (take_mret),
    .wr_en     (csr_wr_ok && csr_addr == ADDR_STATUS),
    .wr_val    (csr_new),
    .priv      (priv_cur),
    .ie        (st_ie),
    .pie       (st_pie),
    .pp        (st_mpp),
    .prv       (st_mprv)
  );

  mpc_trapregs #(.CAUSE_W(CAUSE_W), .TVEC_RST(TVEC_RST)) u_trapregs (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_trap  (take_trap),
    .trap_pc    (trap_pc),
    .trap_cause (trap_cause),
    .epc_we     (csr_wr_ok && csr_addr == ADDR_EPC),
    .cause_we   (csr_wr_ok && csr_addr == ADDR_CAUSE),
    .tvec_we    (csr_wr_ok && csr_addr == ADDR_TVEC),
    .wdata      (csr_new),
    .epc        (st_mepc),
    .cause      (st_cause),
    .tvec       (st_mtvec)
  );

  assign st_status = pack_status(st_ie, st_pie, st_mpp, st_mprv);

  mpc_csr_mux #(.CAUSE_W(CAUSE_W)) u_mux (
    .addr     (csr_addr),
    .status_v (st_status),
    .tvec     (st_mtvec),
    .epc      (st_mepc),
    .cause    (st_cause),
    .rdata    (csr_rdata)
  );

  assign priv_ls        = ls_priv_of(priv_cur, st_mpp, st_mprv);
  assign redirect_valid = take_trap | take_mret;
  assign redirect_pc    = take_trap ? st_mtvec : st_mepc;
endmodule

// File: rtl/mach_priv_ctrl_chk.sv
module mach_priv_ctrl_chk
  import mpc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic            mret_req,
  input logic [1:0]      priv_cur,
  input logic [1:0]      priv_ls,
  input logic [1:0]      st_mpp,
  input logic            st_mprv,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic [XLEN-1:0] st_mepc,
  input logic [XLEN-1:0] st_mtvec
);
  // R4
  trap_enters_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (priv_cur == PRIV_M && st_mpp == $past(priv_cur)));

  // R6
  mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req && !trap_req) |=> (st_mpp == PRIV_U && priv_cur == $past(st_mpp)));

  // R7
  mret_u_mprv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req && !trap_req && st_mpp == PRIV_U) |=> !st_mprv);

  // R7
  mret_m_mprv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req && !trap_req && st_mpp == PRIV_M) |=> st_mprv == $past(st_mprv));

  // R3
  mpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_mpp == PRIV_U || st_mpp == PRIV_M));

  // R9
  ls_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req && !trap_req && st_mprv && st_mpp == PRIV_M) |=> priv_ls == PRIV_U);

  // R9
  ls_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_mprv |-> priv_ls == priv_cur);

  // R5
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (redirect_valid && redirect_pc == st_mtvec));

  // R8
  mret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req && !trap_req) |-> (redirect_valid && redirect_pc == st_mepc));

  // R10
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && mret_req) |=> priv_cur == PRIV_M);
endmodule

bind mach_priv_ctrl mach_priv_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .trap_req       (trap_req),
  .mret_req       (mret_req),
  .priv_cur       (priv_cur),
  .priv_ls        (priv_ls),
  .st_mpp         (st_mpp),
  .st_mprv        (st_mprv),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .st_mepc        (st_mepc),
  .st_mtvec       (st_mtvec)
);

// File: tb/mach_priv_ctrl_bench.sv
module mach_priv_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_req = 1'b0;
  logic [3:0]  trap_cause = '0;
  logic [31:0] trap_pc = '0;
  logic        mret_req = 1'b0;
  logic [1:0]  csr_op = 2'd0;
  logic [11:0] csr_addr = 12'h300;
  logic [31:0] csr_wdata = '0;
  logic [1:0]  priv_cur, priv_ls;
  logic        redirect_valid;
  logic [31:0] redirect_pc, csr_rdata;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mach_priv_ctrl u_mach_priv_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_cause(trap_cause),
    .trap_pc(trap_pc), .mret_req(mret_req), .csr_op(csr_op), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .priv_cur(priv_cur), .priv_ls(priv_ls),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .csr_rdata(csr_rdata)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 csr op on mstatus, 1 trap, 2 mret
    logic [1:0]  op;
    logic [31:0] data;   // csr operand, or cause for a trap
    logic [31:0] exp_ms;
    logic [1:0]  exp_priv;
    logic [1:0]  exp_ls;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd2, 32'h0002_1800, 32'h0002_1800, 2'b11, 2'b11},
    '{2'd2, 2'd0, 32'h0,         32'h0002_0080, 2'b11, 2'b00},
    '{2'd0, 2'd2, 32'h0000_1800, 32'h0002_1880, 2'b11, 2'b11},
    '{2'd1, 2'd0, 32'h7,         32'h0002_1800, 2'b11, 2'b11},
    '{2'd0, 2'd3, 32'h0000_1800, 32'h0002_0000, 2'b11, 2'b00},
    '{2'd2, 2'd0, 32'h0,         32'h0000_0080, 2'b00, 2'b00},
    '{2'd1, 2'd0, 32'h1,         32'h0000_0000, 2'b11, 2'b11},
    '{2'd0, 2'd1, 32'hFFFF_FFFF, 32'h0002_1888, 2'b11, 2'b11},
    '{2'd0, 2'd1, 32'h0000_0800, 32'h0000_0000, 2'b11, 2'b11},
    '{2'd0, 2'd1, 32'h0000_1008, 32'h0000_0008, 2'b11, 2'b11},
    '{2'd1, 2'd0, 32'h3,         32'h0000_1880, 2'b11, 2'b11},
    '{2'd2, 2'd0, 32'h0,         32'h0000_0088, 2'b11, 2'b11},
    '{2'd0, 2'd2, 32'h0002_0000, 32'h0002_0088, 2'b11, 2'b00},
    '{2'd0, 2'd2, 32'h0000_1000, 32'h0002_0088, 2'b11, 2'b00},
    '{2'd0, 2'd3, 32'h0000_0008, 32'h0002_0080, 2'b11, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    csr_addr = a;
    #1;
    v = csr_rdata;
  endtask

  // Drive one cycle of stimulus at a negedge; return at the next negedge, idle.
  task automatic go(input logic t, input logic m, input logic [1:0] op,
                    input logic [11:0] a, input logic [31:0] wd,
                    input logic [3:0] cause, input logic [31:0] pc);
    trap_req = t; mret_req = m; csr_op = op; csr_addr = a; csr_wdata = wd;
    trap_cause = cause; trap_pc = pc;
    @(negedge clk);
    trap_req = 1'b0; mret_req = 1'b0; csr_op = 2'd0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 priv", {30'd0, priv_cur}, 32'h3);
    check("R1 ls", {30'd0, priv_ls}, 32'h3);
    rd(12'h300, v); check("R1 mstatus", v, 32'h0);
    rd(12'h341, v); check("R1 mepc", v, 32'h0);
    rd(12'h342, v); check("R1 mcause", v, 32'h0);
    check("R1 redirect", {31'd0, redirect_valid}, 32'h0);

    // Table walk: R2/R3 csr ops, R4 traps, R6/R7 returns, R9 load/store privilege
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (VECS[i].kind == 2'd0) ? "R2 R3 csr" : (VECS[i].kind == 2'd1) ? "R4 trap" : "R6 R7 mret";
      go(VECS[i].kind == 2'd1, VECS[i].kind == 2'd2, (VECS[i].kind == 2'd0) ? VECS[i].op : 2'd0,
         12'h300, VECS[i].data, VECS[i].data[3:0], 32'h8000_0100);
      rd(12'h300, v);
      check($sformatf("%s step %0d mstatus", tag, i), v, VECS[i].exp_ms);
      check($sformatf("%s step %0d priv", tag, i), {30'd0, priv_cur}, {30'd0, VECS[i].exp_priv});
      check($sformatf("R9 step %0d ls", i), {30'd0, priv_ls}, {30'd0, VECS[i].exp_ls});
    end

    // R11 address map and alignment
    go(1'b0, 1'b0, 2'd1, 12'h305, 32'h0000_4003, 4'd0, 32'h0);
    rd(12'h305, v); check("R11 mtvec", v, 32'h0000_4000);
    go(1'b0, 1'b0, 2'd1, 12'h341, 32'h0000_1235, 4'd0, 32'h0);
    rd(12'h341, v); check("R11 mepc", v, 32'h0000_1234);
    go(1'b0, 1'b0, 2'd1, 12'h342, 32'hFFFF_FFFF, 4'd0, 32'h0);
    rd(12'h342, v); check("R11 mcause width", v, 32'h0000_000F);
    rd(12'h7C0, v); check("R11 unmapped", v, 32'h0);

    // R5 trap redirect, R4 recorded state
    trap_req = 1'b1; trap_cause = 4'd7; trap_pc = 32'h0000_C108;
    #1;
    check("R5 redirect valid", {31'd0, redirect_valid}, 32'h1);
    check("R5 redirect pc", redirect_pc, 32'h0000_4000);
    @(negedge clk); trap_req = 1'b0;
    rd(12'h341, v); check("R4 mepc", v, 32'h0000_C108);
    rd(12'h342, v); check("R4 mcause", v, 32'h7);

    // R8 return redirect
    mret_req = 1'b1;
    #1;
    check("R8 redirect valid", {31'd0, redirect_valid}, 32'h1);
    check("R8 redirect pc", redirect_pc, 32'h0000_C108);
    @(negedge clk); mret_req = 1'b0;

    // R10 trap beats mret, csr write dropped
    trap_req = 1'b1; mret_req = 1'b1; trap_cause = 4'd1; trap_pc = 32'h0000_3000;
    csr_op = 2'd1; csr_addr = 12'h342; csr_wdata = 32'hA;
    #1;
    check("R10 redirect pc", redirect_pc, 32'h0000_4000);
    @(negedge clk); trap_req = 1'b0; mret_req = 1'b0; csr_op = 2'd0;
    check("R10 priv", {30'd0, priv_cur}, 32'h3);
    rd(12'h342, v); check("R10 mcause", v, 32'h1);
    rd(12'h341, v); check("R10 mepc", v, 32'h0000_3000);
    rd(12'h300, v); check("R10 mpp from trap", {30'd0, v[12:11]}, 32'h3);

    // R9 MPP change by mret seen the next cycle; R7 MPRV kept when returning to M
    go(1'b0, 1'b0, 2'd2, 12'h300, 32'h0002_1800, 4'd0, 32'h0);
    mret_req = 1'b1;
    #1;
    check("R9 ls before mret", {30'd0, priv_ls}, 32'h3);
    @(negedge clk); mret_req = 1'b0;
    check("R9 ls after mret", {30'd0, priv_ls}, 32'h0);
    rd(12'h300, v); check("R7 mprv kept", {31'd0, v[17]}, 32'h1);

    // R7 return to User clears MPRV; R6 priv becomes User
    go(1'b0, 1'b1, 2'd0, 12'h300, 32'h0, 4'd0, 32'h0);
    check("R6 priv user", {30'd0, priv_cur}, 32'h0);
    rd(12'h300, v); check("R7 mprv cleared", {31'd0, v[17]}, 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule